// File: doc/BRIEF.md
# Discoverable-Parameter Read Responder

This block is the device-side serial slave that answers a host's request for the self-describing parameter area of a serial flash. The block samples chip select, serial clock and up to four data lines with its own system clock. It decodes a one-byte instruction and a 24-bit start address, and lets eight idle clocks pass. It then streams bytes from a small internal parameter image, one after another, until chip select is released. The image begins with a header: a four-character signature, a revision pair, a count of parameter headers and one parameter header that points to a following parameter table.

A static mode input sets how many data lines every phase of the command uses: one, two or four. The instruction, the address length, the eight-clock latency and the byte order are the same in all three modes. Reads only move forward. Any address beyond the image returns the fill value FFh, so nothing past the image can ever reach main storage contents.

Top module: `dpr_read_responder`

## Requirements
- R1: After reset, and from shortly after chip select (`cs_n`) goes high, all `dq_oe` bits are 0. Raising `cs_n` at any point abandons the command, and the next selection starts again with the instruction.
- R2: Only the instruction byte 5Ah starts a read. With any other instruction, `dq_oe` stays 0 until the end of that selection.
- R3: `mode_sel` = 0 (and the unused value 3) selects single-line mode: input on DQ0, output on DQ1, and 8 clocks for the instruction. `mode_sel` = 1 selects dual mode on DQ1:DQ0, and the instruction takes 4 clocks. `mode_sel` = 2 selects quad mode on DQ3:DQ0, and the instruction takes 2 clocks. Values are sent most significant bit first, and DQ0 carries the least significant bit of each bit group.
- R4: The address is always 24 bits, which takes 24, 12 or 6 clocks. Exactly 8 idle clocks follow it. The first data group is driven after the falling clock edge that follows the 8th idle rising edge, and the host samples it on the next rising edge. `dq_oe` is 0 through the instruction, address and idle phases.
- R5: Bytes come from consecutive increasing addresses for as long as the clock runs, with no wrap-around.
- R6: Addresses at or above the image size (32 bytes by default) return FFh. At address FFFFFFh the address stays there and does not wrap to 0.
- R7: Bytes 0..3 are 53h 46h 44h 50h. Byte 4 is the minor revision (default 06h), byte 5 the major revision (default 01h), byte 6 the header count field (default 00h), and byte 7 is FFh.
- R8: Bytes 8..15 are the parameter header: 00h, minor 06h, major 01h, length 04h (in 32-bit words), table pointer bytes 10h 00h 00h (least significant first), then FFh. Table byte k at 10h+k (k = 0..15) holds 20h+k.
- R9: While data is driven, `dq_oe` is 0010b in single mode, 0011b in dual mode and 1111b in quad mode. `dq_out` changes only in response to a falling clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Lane mode: 0 single, 1 dual, 2 quad, 3 treated as single |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| dq_in | input | 4 | Data lines as seen at the pins |
| dq_out | output | 4 | Data driven toward the pins |
| dq_oe | output | 4 | Per-line output enable |

## Verification
The assertions assume that `mode_sel` does not change while the block is selected. They also assume each `sck` level lasts several system clocks, so that the synchronizers and the registered output settle within half a serial clock. The bench holds the mode fixed for each selection. It runs the serial clock at eight system clocks per level, changes `dq_in` and `cs_n` only while `sck` is low, and samples `dq_out` just before each rising edge. Transactions draw random modes, start addresses inside, near and far beyond the image, and byte counts. Directed cases cover a wrong instruction, aborts in the middle of the address and in the middle of the data, and reads that end at the top of the address space.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  localparam logic [7:0] READ_OPCODE = 8'h5A;
  localparam int         ADDR_BITS   = 24;
  localparam int         IDLE_CLKS   = 8;

  typedef enum logic [2:0] {
    PH_INSTR,
    PH_ADDR,
    PH_IDLE,
    PH_DATA,
    PH_IGNORE
  } phase_t;

  // lanes in use for a mode code
  function automatic logic [2:0] lane_count(input logic [1:0] mode);
    case (mode)
      2'd1:    lane_count = 3'd2;
      2'd2:    lane_count = 3'd4;
      default: lane_count = 3'd1;
    endcase
  endfunction

  // output enable pattern while data is driven
  function automatic logic [3:0] drive_mask(input logic [1:0] mode);
    case (mode)
      2'd1:    drive_mask = 4'b0011;
      2'd2:    drive_mask = 4'b1111;
      default: drive_mask = 4'b0010;
    endcase
  endfunction

endpackage

// File: rtl/dpr_pin_sync.sv
module dpr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sck,
  input  logic [3:0] dq_in,
  output logic       cs_q,
  output logic [3:0] dq_q,
  output logic       sck_rise,
  output logic       sck_fall
);

  logic [STAGES-1:0] cs_pipe;
  logic [STAGES-1:0] sck_pipe;
  logic [3:0]        dq_pipe [STAGES];
  logic              sck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_pipe  <= '1;
      sck_pipe <= '0;
      sck_prev <= 1'b0;
    end else begin
      cs_pipe  <= {cs_pipe[STAGES-2:0], cs_n};
      sck_pipe <= {sck_pipe[STAGES-2:0], sck};
      sck_prev <= sck_pipe[STAGES-1];
    end
  end

  always_ff @(posedge clk) begin
    dq_pipe[0] <= dq_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_dq_stage
    always_ff @(posedge clk) begin
      dq_pipe[s] <= dq_pipe[s-1];
    end
  end

  assign cs_q     = cs_pipe[STAGES-1];
  assign dq_q     = dq_pipe[STAGES-1];
  assign sck_rise = sck_pipe[STAGES-1] & ~sck_prev;
  assign sck_fall = ~sck_pipe[STAGES-1] & sck_prev;

endmodule

// File: rtl/dpr_param_rom.sv
module dpr_param_rom #(
  parameter int         ROM_BYTES  = 32,
  parameter logic [7:0] REV_MINOR  = 8'h06,
  parameter logic [7:0] REV_MAJOR  = 8'h01,
  parameter logic [7:0] HDR_COUNT  = 8'h00,
  parameter int         TBL_PTR    = 16,
  parameter int         TBL_DWORDS = 4,
  parameter logic [7:0] TBL_BASE   = 8'h20
) (
  input  logic        clk,
  input  logic [23:0] rd_addr,
  output logic [7:0]  rd_data
);

  localparam int AW      = $clog2(ROM_BYTES);
  localparam int TBL_END = TBL_PTR + 4 * TBL_DWORDS;

  logic [7:0] mem [ROM_BYTES];

  function automatic logic [7:0] image_byte(input int idx);
    logic [23:0] ptr;
    ptr = 24'(TBL_PTR);
    case (idx)
      0:  image_byte = 8'h53;
      1:  image_byte = 8'h46;
      2:  image_byte = 8'h44;
      3:  image_byte = 8'h50;
      4:  image_byte = REV_MINOR;
      5:  image_byte = REV_MAJOR;
      6:  image_byte = HDR_COUNT;
      8:  image_byte = 8'h00;
      9:  image_byte = REV_MINOR;
      10: image_byte = REV_MAJOR;
      11: image_byte = 8'(TBL_DWORDS);
      12: image_byte = ptr[7:0];
      13: image_byte = ptr[15:8];
      14: image_byte = ptr[23:16];
      default: begin
        if (idx >= TBL_PTR && idx < TBL_END) image_byte = TBL_BASE + 8'(idx - TBL_PTR);
        else                                 image_byte = 8'hFF;
      end
    endcase
  endfunction

  initial begin
    for (int i = 0; i < ROM_BYTES; i++) mem[i] = image_byte(i);
  end

  always_ff @(posedge clk) begin
    if (rd_addr < 24'(ROM_BYTES)) rd_data <= mem[rd_addr[AW-1:0]];
    else                          rd_data <= 8'hFF;
  end

endmodule

// File: rtl/dpr_cmd_engine.sv
module dpr_cmd_engine
  import dpr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  mode_sel,
  input  logic        cs_q,
  input  logic        sck_rise,
  input  logic        sck_fall,
  input  logic [3:0]  dq_q,
  input  logic [7:0]  rom_data,
  output logic [23:0] rd_addr,
  output logic [3:0]  dq_out,
  output logic [3:0]  dq_oe,
  output phase_t      phase
);

  localparam int          CW        = $clog2(ADDR_BITS);
  localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_CLKS - 1);

  logic [ADDR_BITS-1:0] sh, sh_nxt;
  logic [CW-1:0]        cnt, instr_last, addr_last;
  logic [2:0]           grp, grp_last, shamt;
  logic [7:0]           shifted;
  logic [3:0]           grp_bits;

  always_comb begin
    case (lane_count(mode_sel))
      3'd2: begin
        sh_nxt     = {sh[ADDR_BITS-3:0], dq_q[1:0]};
        instr_last = CW'(3);
        addr_last  = CW'(11);
        grp_last   = 3'd3;
        shamt      = {grp[1:0], 1'b0};
      end
      3'd4: begin
        sh_nxt     = {sh[ADDR_BITS-5:0], dq_q};
        instr_last = CW'(1);
        addr_last  = CW'(5);
        grp_last   = 3'd1;
        shamt      = {grp[0], 2'b00};
      end
      default: begin
        sh_nxt     = {sh[ADDR_BITS-2:0], dq_q[0]};
        instr_last = CW'(7);
        addr_last  = CW'(23);
        grp_last   = 3'd7;
        shamt      = grp;
      end
    endcase
  end

  always_comb begin
    shifted = rom_data << shamt;
    case (lane_count(mode_sel))
      3'd2:    grp_bits = {2'b00, shifted[7:6]};
      3'd4:    grp_bits = shifted[7:4];
      default: grp_bits = {2'b00, shifted[7], 1'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_INSTR;
      cnt     <= '0;
      grp     <= '0;
      sh      <= '0;
      rd_addr <= '0;
      dq_out  <= '0;
      dq_oe   <= '0;
    end else if (cs_q) begin
      phase <= PH_INSTR;
      cnt   <= '0;
      grp   <= '0;
      dq_oe <= '0;
    end else if (sck_rise) begin
      case (phase)
        PH_INSTR: begin
          sh <= sh_nxt;
          if (cnt == instr_last) begin
            cnt   <= '0;
            phase <= (sh_nxt[7:0] == READ_OPCODE) ? PH_ADDR : PH_IGNORE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ADDR: begin
          sh <= sh_nxt;
          if (cnt == addr_last) begin
            cnt     <= '0;
            rd_addr <= sh_nxt;
            phase   <= PH_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_IDLE: begin
          if (cnt == IDLE_LAST) begin
            cnt   <= '0;
            grp   <= '0;
            phase <= PH_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end else if (sck_fall && phase == PH_DATA) begin
      dq_oe  <= drive_mask(mode_sel);
      dq_out <= grp_bits;
      if (grp == grp_last) begin
        grp <= '0;
        if (rd_addr != '1) rd_addr <= rd_addr + 1'b1;
      end else begin
        grp <= grp + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dpr_read_responder.sv
module dpr_read_responder
  import dpr_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         ROM_BYTES   = 32,
  parameter logic [7:0] REV_MINOR   = 8'h06,
  parameter logic [7:0] REV_MAJOR   = 8'h01,
  parameter logic [7:0] HDR_COUNT   = 8'h00,
  parameter int         TBL_PTR     = 16,
  parameter int         TBL_DWORDS  = 4,
  parameter logic [7:0] TBL_BASE    = 8'h20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic       cs_n,
  input  logic       sck,
  input  logic [3:0] dq_in,
  output logic [3:0] dq_out,
  output logic [3:0] dq_oe
);

  logic        cs_q, sck_rise, sck_fall;
  logic [3:0]  dq_q;
  logic [23:0] rd_addr;
  logic [7:0]  rom_data;
  phase_t      phase;

  dpr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sck      (sck),
    .dq_in    (dq_in),
    .cs_q     (cs_q),
    .dq_q     (dq_q),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall)
  );

  dpr_param_rom #(
    .ROM_BYTES  (ROM_BYTES),
    .REV_MINOR  (REV_MINOR),
    .REV_MAJOR  (REV_MAJOR),
    .HDR_COUNT  (HDR_COUNT),
    .TBL_PTR    (TBL_PTR),
    .TBL_DWORDS (TBL_DWORDS),
    .TBL_BASE   (TBL_BASE)
  ) u_rom (
    .clk     (clk),
    .rd_addr (rd_addr),
    .rd_data (rom_data)
  );

  dpr_cmd_engine u_engine (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .cs_q     (cs_q),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .dq_q     (dq_q),
    .rom_data (rom_data),
    .rd_addr  (rd_addr),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe),
    .phase    (phase)
  );

endmodule

// File: rtl/dpr_checker.sv
module dpr_checker
  import dpr_pkg::*;
#(
  parameter int ROM_BYTES = 32
) (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  mode_sel,
  input logic        cs_q,
  input logic        sck_fall,
  input phase_t      phase,
  input logic [23:0] rd_addr,
  input logic [7:0]  rom_data,
  input logic [3:0]  dq_out,
  input logic [3:0]  dq_oe
);

  AST_IDLE_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    cs_q |=> dq_oe == 4'b0000); // R1

  AST_QUIET_OUTSIDE_DATA: assert property (@(posedge clk) disable iff (rst)
    phase != PH_DATA |-> dq_oe == 4'b0000); // R2

  AST_QUIET_BEFORE_DATA: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE || phase == PH_ADDR) |-> dq_oe == 4'b0000); // R4

  AST_LANE_MASK: assert property (@(posedge clk) disable iff (rst)
    dq_oe != 4'b0000 |-> dq_oe == drive_mask(mode_sel)); // R9

  AST_CHANGE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !sck_fall |=> $stable(dq_out)); // R9

  AST_FORWARD_ONLY: assert property (@(posedge clk) disable iff (rst)
    phase == PH_DATA |=> (rd_addr == $past(rd_addr) || rd_addr == $past(rd_addr) + 24'd1)); // R5

  AST_FILL_PAST_END: assert property (@(posedge clk) disable iff (rst)
    rd_addr >= 24'(ROM_BYTES) |=> rom_data == 8'hFF); // R6

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA && rd_addr == 24'hFFFFFF) |=> rd_addr == 24'hFFFFFF); // R6

endmodule

bind dpr_read_responder dpr_checker #(.ROM_BYTES(ROM_BYTES)) u_checker (
  .clk      (clk),
  .rst      (rst),
  .mode_sel (mode_sel),
  .cs_q     (cs_q),
  .sck_fall (sck_fall),
  .phase    (phase),
  .rd_addr  (rd_addr),
  .rom_data (rom_data),
  .dq_out   (dq_out),
  .dq_oe    (dq_oe)
);

// File: tb/tb_dpr_read_responder.sv
module tb_dpr_read_responder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'd0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic [3:0] dq_in = 4'h0;
  logic [3:0] dq_out, dq_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  bit drive_seen;

  always #4 clk = ~clk;

  dpr_read_responder dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .cs_n(cs_n),
    .sck(sck), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic int lanes(input int m);
    return (m == 1) ? 2 : (m == 2) ? 4 : 1;
  endfunction

  function automatic logic [3:0] exp_mask(input int m);
    return (m == 1) ? 4'b0011 : (m == 2) ? 4'b1111 : 4'b0010;
  endfunction

  // image contents per R7 and R8, fill per R6
  function automatic logic [7:0] exp_byte(input logic [23:0] a);
    case (a)
      24'd0: return 8'h53;  24'd1: return 8'h46;
      24'd2: return 8'h44;  24'd3: return 8'h50;
      24'd4: return 8'h06;  24'd5: return 8'h01;
      24'd6: return 8'h00;  24'd7: return 8'hFF;
      24'd8: return 8'h00;  24'd9: return 8'h06;
      24'd10: return 8'h01; 24'd11: return 8'h04;
      24'd12: return 8'h10; 24'd13: return 8'h00;
      24'd14: return 8'h00; 24'd15: return 8'hFF;
      default: return (a >= 24'd16 && a < 24'd32) ? 8'h20 + 8'(a - 24'd16) : 8'hFF;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  // one serial clock with host data; notes any drive seen before the rising edge
  task automatic cycle_in(input logic [3:0] v);
    dq_in = v;
    half();
    if (dq_oe != 4'b0000) drive_seen = 1;
    sck = 1'b1;
    half();
    sck = 1'b0;
  endtask

  task automatic send(input logic [23:0] val, input int nbits, input int w);
    for (int k = 0; k < nbits / w; k++) begin
      logic [23:0] g;
      g = (val >> (nbits - (k + 1) * w)) & 24'((1 << w) - 1);
      cycle_in(g[3:0]);
    end
  endtask

  task automatic run_cmd(input int m, input logic [7:0] op, input logic [23:0] a, input int n);
    int w;
    w = lanes(m);
    mode_sel = 2'(m);
    drive_seen = 0;
    cs_n = 1'b0;
    half();
    send({16'h0, op}, 8, w);
    send(a, 24, w);
    for (int d = 0; d < 8; d++) cycle_in(4'h0);
    chk("R4 quiet through instr/addr/idle", 32'(drive_seen), 0);
    if (op == 8'h5A) begin
      for (int i = 0; i < n; i++) begin
        logic [7:0] b;
        logic [23:0] ea;
        bit mask_ok;
        b = 0;
        mask_ok = 1;
        for (int g = 0; g < 8 / w; g++) begin
          half();
          if (dq_oe != exp_mask(m)) mask_ok = 0;
          case (w)
            1: b = {b[6:0], dq_out[1]};
            2: b = {b[5:0], dq_out[1:0]};
            default: b = {b[3:0], dq_out};
          endcase
          sck = 1'b1;
          half();
          sck = 1'b0;
        end
        ea = (32'(a) + 32'(i) > 32'hFFFFFF) ? 24'hFFFFFF : a + 24'(i);
        chk($sformatf("R5 R7 R8 R6 byte m%0d a%0h i%0d", m, a, i), {24'h0, b}, {24'h0, exp_byte(ea)});
        chk("R9 R3 lane enables", {28'h0, mask_ok ? exp_mask(m) : 4'h0}, {28'h0, exp_mask(m)});
      end
    end else begin
      drive_seen = 0;
      for (int k = 0; k < n * 8; k++) cycle_in(4'hF);
      chk("R2 wrong instruction not driven", 32'(drive_seen), 0);
    end
    cs_n = 1'b1;
    half();
    half();
    chk("R1 released after deselect", {28'h0, dq_oe}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (4) @(negedge clk);
    chk("R1 reset outputs", {28'h0, dq_oe}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 idle outputs", {28'h0, dq_oe}, 0);

    // header in each mode (R3, R7, R8)
    run_cmd(2, 8'h5A, 24'h000000, 8);
    run_cmd(0, 8'h5A, 24'h000000, 12);
    run_cmd(1, 8'h5A, 24'h00000C, 6);
    // crossing the end of the image (R6, R5)
    run_cmd(1, 8'h5A, 24'h00001C, 8);
    // wrong instruction (R2)
    run_cmd(0, 8'h03, 24'h000000, 2);
    run_cmd(2, 8'hA5, 24'h000004, 2);
    // abort in the address, then a clean read (R1)
    mode_sel = 2'd2;
    cs_n = 1'b0;
    half();
    send(24'h5A, 8, 4);
    send(24'h12, 8, 4);
    cs_n = 1'b1;
    half();
    half();
    chk("R1 abort in address", {28'h0, dq_oe}, 0);
    run_cmd(2, 8'h5A, 24'h000004, 3);
    // abort in the data (R1)
    run_cmd(0, 8'h5A, 24'h000010, 2);
    // top of address space, no wrap (R6)
    run_cmd(2, 8'h5A, 24'hFFFFFE, 4);
    run_cmd(0, 8'h5A, 24'hFFFFFF, 2);

    for (int t = 0; t < 30; t++) begin
      int m;
      logic [23:0] a;
      int pick;
      m = int'($urandom % 3);
      pick = int'($urandom % 4);
      a = (pick == 3) ? 24'($urandom) : 24'($urandom % 40);
      run_cmd(m, ($urandom % 8 == 0) ? 8'($urandom) | 8'h01 : 8'h5A, a, 1 + int'($urandom % 6));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule